// File: doc/BRIEF.md
# Data Watchpoint Range Match Unit

This block holds a small bank of programmable data watchpoint slots and compares every load or store the core makes against them. A slot can guard one or more contiguous bytes inside one aligned doubleword, or a naturally aligned power-of-two region of memory. A slot can be limited to loads, to stores, or to both, and to user privilege, kernel privilege, or both. Only standalone slots are supported. A slot marked as linked never fires.

Each slot has a 32-bit control word and a 64-bit base address. Both are written through one shared configuration write port. An access gives the start address, a size code, a load/store flag and a privilege flag. One cycle later the block reports whether any slot matched, and which matching slot has the lowest index.

Top module: `wp_match_unit`

## Requirements
- R1: After reset every control word is zero, so no slot is enabled. The outputs `hit` and `hit_slot` are both 0.
- R2: `hit` and `hit_slot` are registered. They describe the access that was presented in the cycle before. When no access was presented, or no slot matched, `hit` is 0 and `hit_slot` is 0.
- R3: A slot can match only when its enable bit (control bit 0) is 1.
- R4: When the mask field (control bits 28:24) is 0, a slot matches if some accessed byte lies in the base doubleword and its byte offset is set in the byte-select field (control bits 12:5, where bit 5 selects offset 0). Bits 2:0 of the base value are ignored.
- R5: An access that runs past the end of a doubleword is checked byte by byte. Bytes that fall in the next doubleword can therefore match a slot whose base lies there.
- R6: When the mask field holds a value N of 3 or more, a slot matches if the start address and the base agree above bit N-1. That region is a naturally aligned block of 2^N bytes.
- R7: A mask value of 1 or 2, a load/store field of 2'b00, or a linked flag of 1 (control bit 20) stops that slot from matching.
- R8: The load/store field (control bits 4:3) takes these values: 2'b01 matches loads only, 2'b10 matches stores only, and 2'b11 matches both. `acc_store` is 1 for a store.
- R9: The privilege field (control bits 2:1) takes these values: bit 1 allows user accesses, and bit 2 allows kernel accesses. `acc_priv` is 1 for kernel.
- R10: When several slots match, `hit_slot` reports the lowest matching index.
- R11: Setting `cfg_sel` to 0 writes the low 32 bits of `cfg_wdata` to the control word. Setting it to 1 writes the 64-bit base value. A write affects accesses from the following cycle onward. An access in the same cycle as the write still sees the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the control word, 1 selects the base value |
| cfg_slot | input | IDX_W | Slot being written |
| cfg_wdata | input | 64 | Write data |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 64 | Access start address |
| acc_size | input | 2 | Size code: 0, 1, 2, 3 mean 1, 2, 4, 8 bytes |
| acc_store | input | 1 | 1 for a store, 0 for a load |
| acc_priv | input | 1 | 1 for kernel, 0 for user |
| hit | output | 1 | A slot matched the previous access |
| hit_slot | output | IDX_W | Lowest matching slot index |

## Verification
Both results are due exactly one clock edge after the access that causes them. The bench drives each access on a falling edge and reads `hit` and `hit_slot` on the next falling edge, so exactly one rising edge lies between stimulus and sample. A configuration write takes one edge to land. The bench therefore applies a write and an access together and expects the old outcome at the first sample, then repeats the access and expects the new outcome. After each access the bench returns the access inputs to idle, so a further sample one cycle later has to read 0 on both outputs.

// File: rtl/wp_pkg.sv
package wp_pkg;

  localparam int VA_W = 64;

  typedef struct packed {
    logic       en;
    logic [1:0] priv_ok;
    logic [1:0] kind_ok;
    logic [7:0] byte_sel;
    logic       linked;
    logic [4:0] span_log2;
  } wp_ctrl_t;

  function automatic wp_ctrl_t unpack_ctrl(logic [31:0] w);
    wp_ctrl_t c;
    c.en        = w[0];
    c.priv_ok   = w[2:1];
    c.kind_ok   = w[4:3];
    c.byte_sel  = w[12:5];
    c.linked    = w[20];
    c.span_log2 = w[28:24];
    return c;
  endfunction

  // Byte-by-byte overlap of an access with the selected bytes of one doubleword
  function automatic logic byte_window_hit(logic [VA_W-1:0] addr, logic [1:0] size_code,
                                           logic [VA_W-1:0] base, logic [7:0] sel);
    logic [VA_W-1:0] a;
    logic [3:0]      nb;
    logic            h;
    h  = 1'b0;
    nb = 4'd1 << size_code;
    for (int i = 0; i < 8; i++) begin
      a = addr + VA_W'(i);
      if ((4'(i) < nb) && (a[VA_W-1:3] == base[VA_W-1:3]) && sel[a[2:0]]) h = 1'b1;
    end
    return h;
  endfunction

  // Aligned power-of-two region compare
  function automatic logic region_hit(logic [VA_W-1:0] addr, logic [VA_W-1:0] base,
                                      logic [4:0] n);
    logic [VA_W-1:0] keep;
    keep = {VA_W{1'b1}} << n;
    return (addr & keep) == (base & keep);
  endfunction

  function automatic logic kind_pass(logic [1:0] kind_ok, logic is_store);
    return is_store ? kind_ok[1] : kind_ok[0];
  endfunction

  function automatic logic priv_pass(logic [1:0] priv_ok, logic kernel);
    return kernel ? priv_ok[1] : priv_ok[0];
  endfunction

endpackage

// File: rtl/wp_slot.sv
module wp_slot
  import wp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_ctrl,
  input  logic            we_base,
  input  logic [63:0]     wdata,
  input  logic [VA_W-1:0] acc_addr,
  input  logic [1:0]      acc_size,
  input  logic            acc_store,
  input  logic            acc_priv,
  output logic            armed,
  output logic            match
);

  logic [31:0]     ctrl_q;
  logic [VA_W-1:0] base_q;
  wp_ctrl_t        c;
  logic            span_reserved;
  logic            addr_ok;
  logic            filt_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      base_q <= '0;
    end else begin
      if (we_ctrl) ctrl_q <= wdata[31:0];
      if (we_base) base_q <= wdata[VA_W-1:0];
    end
  end

  always_comb begin
    c             = unpack_ctrl(ctrl_q);
    span_reserved = (c.span_log2 == 5'd1) || (c.span_log2 == 5'd2);
    if (c.span_log2 == 5'd0) addr_ok = byte_window_hit(acc_addr, acc_size, base_q, c.byte_sel);
    else                     addr_ok = region_hit(acc_addr, base_q, c.span_log2);
    filt_ok = kind_pass(c.kind_ok, acc_store) && priv_pass(c.priv_ok, acc_priv)
              && !c.linked && !span_reserved;
  end

  assign armed = c.en;
  assign match = c.en && filt_ok && addr_ok;

endmodule

// File: rtl/wp_lowest.sv
module wp_lowest #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/wp_match_unit.sv
module wp_match_unit
  import wp_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [IDX_W-1:0] cfg_slot,
  input  logic [63:0]      cfg_wdata,
  input  logic             acc_valid,
  input  logic [63:0]      acc_addr,
  input  logic [1:0]       acc_size,
  input  logic             acc_store,
  input  logic             acc_priv,
  output logic             hit,
  output logic [IDX_W-1:0] hit_slot
);

  logic [SLOTS-1:0] slot_match;
  logic [SLOTS-1:0] slot_en;
  logic             any_match;
  logic [IDX_W-1:0] first_idx;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic sel_here;
    assign sel_here = cfg_we && (cfg_slot == IDX_W'(g));
    wp_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .we_ctrl   (sel_here && !cfg_sel),
      .we_base   (sel_here && cfg_sel),
      .wdata     (cfg_wdata),
      .acc_addr  (acc_addr),
      .acc_size  (acc_size),
      .acc_store (acc_store),
      .acc_priv  (acc_priv),
      .armed     (slot_en[g]),
      .match     (slot_match[g])
    );
  end

  wp_lowest #(.N(SLOTS), .IDX_W(IDX_W)) u_lowest (
    .req (slot_match),
    .any (any_match),
    .idx (first_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit      <= 1'b0;
      hit_slot <= '0;
    end else begin
      hit      <= acc_valid && any_match;
      hit_slot <= (acc_valid && any_match) ? first_idx : '0;
    end
  end

endmodule

// File: rtl/wp_match_chk.sv
module wp_match_chk #(
  parameter int SLOTS = 4,
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic             hit,
  input logic [IDX_W-1:0] hit_slot,
  input logic [SLOTS-1:0] slot_match,
  input logic [SLOTS-1:0] slot_en
);

  function automatic logic [SLOTS-1:0] below(logic [IDX_W-1:0] k);
    logic [SLOTS-1:0] m;
    for (int i = 0; i < SLOTS; i++) m[i] = (i < int'(k));
    return m;
  endfunction

  // R2
  hit_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(acc_valid));

  // R2
  idle_index_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (hit_slot == '0));

  // R2
  match_reported_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc_valid) && ($past(slot_match) != '0)) |-> hit);

  // R10
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (($past(slot_match) & below(hit_slot)) == '0));

  // R10
  reported_slot_matched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((($past(slot_match) >> hit_slot) & SLOTS'(1)) != '0));

  for (genvar g = 0; g < SLOTS; g++) begin : g_quiet
    // R3
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_en[g] |-> !slot_match[g]);
  end

endmodule

bind wp_match_unit wp_match_chk #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .hit        (hit),
  .hit_slot   (hit_slot),
  .slot_match (slot_match),
  .slot_en    (slot_en)
);

// File: tb/wp_match_unit_bench.sv
`timescale 1ns/100ps
module wp_match_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [1:0]  cfg_slot = '0;
  logic [63:0] cfg_wdata = '0;
  logic        acc_valid = 1'b0;
  logic [63:0] acc_addr = '0;
  logic [1:0]  acc_size = '0;
  logic        acc_store = 1'b0;
  logic        acc_priv = 1'b0;
  logic        hit;
  logic [1:0]  hit_slot;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  wp_match_unit u_wp_match_unit (
    .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_slot, .cfg_wdata,
    .acc_valid, .acc_addr, .acc_size, .acc_store, .acc_priv,
    .hit, .hit_slot
  );

  function automatic logic [63:0] mk(bit en, logic [1:0] pv, logic [1:0] ls,
                                     logic [7:0] bs, logic [4:0] ms, bit lk);
    return 64'({ms, 3'b000, lk, 7'b0, bs, ls, pv, en});
  endfunction

  task automatic check(string req, logic h, logic [1:0] s, logic eh, logic [1:0] es);
    n_vec++;
    if (h !== eh || s !== es) begin
      n_bad++;
      $display("FAIL %s: hit=%0b slot=%0d expected hit=%0b slot=%0d", req, h, s, eh, es);
    end
  endtask

  task automatic wr(int s, bit sel, logic [63:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_slot = 2'(s); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_all();
    for (int s = 0; s < 4; s++) wr(s, 1'b0, 64'd0);
  endtask

  task automatic probe(string req, logic [63:0] a, logic [1:0] sz, bit st, bit pv,
                       bit eh, int es);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_size = sz; acc_store = st; acc_priv = pv;
    @(negedge clk);
    check(req, hit, hit_slot, eh, eh ? 2'(es) : 2'd0);
    acc_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", hit, hit_slot, 1'b0, 2'd0);
    probe("R1", 64'h0, 2'd3, 0, 1, 0, 0);
  endtask

  task automatic t_bytes();
    clear_all();
    wr(0, 1, 64'h1005);
    wr(0, 0, mk(1, 2'b11, 2'b11, 8'h30, 5'd0, 0));
    probe("R4", 64'h1004, 2'd0, 0, 0, 1, 0);
    probe("R4", 64'h1003, 2'd0, 0, 0, 0, 0);
    probe("R4", 64'h1000, 2'd3, 0, 0, 1, 0);
    probe("R4", 64'h1006, 2'd1, 0, 0, 0, 0);
    probe("R4", 64'h2004, 2'd0, 0, 0, 0, 0);
    probe("R4", 64'h1002, 2'd2, 1, 1, 1, 0);
  endtask

  task automatic t_cross();
    clear_all();
    wr(1, 1, 64'h2000);
    wr(1, 0, mk(1, 2'b11, 2'b11, 8'h01, 5'd0, 0));
    probe("R5", 64'h1FFE, 2'd2, 0, 0, 1, 1);
    probe("R5", 64'h1FFC, 2'd2, 0, 0, 0, 0);
    wr(0, 1, 64'h1FF8);
    wr(0, 0, mk(1, 2'b11, 2'b11, 8'h80, 5'd0, 0));
    probe("R5", 64'h1FFE, 2'd2, 0, 0, 1, 0);
  endtask

  task automatic t_enable();
    clear_all();
    wr(1, 1, 64'h2000);
    wr(1, 0, mk(0, 2'b11, 2'b11, 8'hFF, 5'd0, 0));
    probe("R3", 64'h2000, 2'd3, 0, 0, 0, 0);
    wr(1, 0, mk(1, 2'b11, 2'b11, 8'hFF, 5'd0, 0));
    probe("R3", 64'h2000, 2'd3, 0, 0, 1, 1);
  endtask

  task automatic t_mask();
    clear_all();
    wr(2, 1, 64'h40123);
    wr(2, 0, mk(1, 2'b11, 2'b11, 8'hFF, 5'd12, 0));
    probe("R6", 64'h40FFF, 2'd0, 0, 0, 1, 2);
    probe("R6", 64'h41000, 2'd0, 0, 0, 0, 0);
    probe("R6", 64'h3FFFF, 2'd0, 0, 0, 0, 0);
    probe("R6", 64'h40800, 2'd3, 1, 1, 1, 2);
  endtask

  task automatic t_reserved();
    clear_all();
    wr(2, 1, 64'h40000);
    wr(2, 0, mk(1, 2'b11, 2'b11, 8'hFF, 5'd1, 0));
    probe("R7", 64'h40000, 2'd0, 0, 0, 0, 0);
    wr(2, 0, mk(1, 2'b11, 2'b11, 8'hFF, 5'd2, 0));
    probe("R7", 64'h40000, 2'd0, 0, 0, 0, 0);
    wr(2, 0, mk(1, 2'b11, 2'b00, 8'hFF, 5'd12, 0));
    probe("R7", 64'h40000, 2'd0, 1, 0, 0, 0);
    wr(2, 0, mk(1, 2'b11, 2'b11, 8'hFF, 5'd12, 1));
    probe("R7", 64'h40000, 2'd0, 0, 0, 0, 0);
    wr(2, 0, mk(1, 2'b11, 2'b11, 8'hFF, 5'd12, 0));
    probe("R7", 64'h40000, 2'd0, 0, 0, 1, 2);
  endtask

  task automatic t_kind();
    clear_all();
    wr(3, 1, 64'h5000);
    wr(3, 0, mk(1, 2'b11, 2'b01, 8'hFF, 5'd0, 0));
    probe("R8", 64'h5000, 2'd2, 0, 0, 1, 3);
    probe("R8", 64'h5000, 2'd2, 1, 0, 0, 0);
    wr(3, 0, mk(1, 2'b11, 2'b10, 8'hFF, 5'd0, 0));
    probe("R8", 64'h5000, 2'd2, 0, 0, 0, 0);
    probe("R8", 64'h5000, 2'd2, 1, 0, 1, 3);
  endtask

  task automatic t_priv();
    clear_all();
    wr(3, 1, 64'h5000);
    wr(3, 0, mk(1, 2'b01, 2'b11, 8'hFF, 5'd0, 0));
    probe("R9", 64'h5004, 2'd0, 0, 0, 1, 3);
    probe("R9", 64'h5004, 2'd0, 0, 1, 0, 0);
    wr(3, 0, mk(1, 2'b10, 2'b11, 8'hFF, 5'd0, 0));
    probe("R9", 64'h5004, 2'd0, 0, 1, 1, 3);
    probe("R9", 64'h5004, 2'd0, 0, 0, 0, 0);
    wr(3, 0, mk(1, 2'b00, 2'b11, 8'hFF, 5'd0, 0));
    probe("R9", 64'h5004, 2'd0, 0, 1, 0, 0);
  endtask

  task automatic t_prio();
    clear_all();
    wr(0, 1, 64'h40000);
    wr(0, 0, mk(1, 2'b11, 2'b11, 8'hFF, 5'd0, 0));
    wr(2, 1, 64'h40000);
    wr(2, 0, mk(1, 2'b11, 2'b11, 8'hFF, 5'd12, 0));
    wr(3, 1, 64'h40000);
    wr(3, 0, mk(1, 2'b11, 2'b11, 8'hFF, 5'd0, 0));
    probe("R10", 64'h40000, 2'd0, 0, 0, 1, 0);
    wr(0, 0, 64'd0);
    probe("R10", 64'h40000, 2'd0, 0, 0, 1, 2);
    probe("R10", 64'h40010, 2'd0, 0, 0, 1, 2);
  endtask

  task automatic t_timing();
    clear_all();
    wr(0, 1, 64'h6000);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_slot = 2'd0;
    cfg_wdata = mk(1, 2'b11, 2'b11, 8'hFF, 5'd0, 0);
    acc_valid = 1'b1; acc_addr = 64'h6000; acc_size = 2'd0; acc_store = 0; acc_priv = 0;
    @(negedge clk);
    cfg_we = 1'b0; acc_valid = 1'b0;
    check("R11", hit, hit_slot, 1'b0, 2'd0);
    probe("R11", 64'h6000, 2'd0, 0, 0, 1, 0);
    @(negedge clk);
    check("R2", hit, hit_slot, 1'b0, 2'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bytes();
    t_cross();
    t_enable();
    t_mask();
    t_reserved();
    t_kind();
    t_priv();
    t_prio();
    t_timing();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule